// File: doc/BRIEF.md
# SPI Host Shift Engine

This block is the serial datapath of an SPI host. A single configuration word chooses the serial clock rate, the clock polarity and phase, the slave-select pattern and the start policy. A separate enable input gates the whole engine. Words arrive on a valid/ready transmit interface. Each accepted word is shifted out most significant bit first while the word from the slave is shifted in. The received word is returned with a one-cycle valid pulse.

The serial clock runs at the reference clock divided by a power of two taken from the divisor field. Polarity and phase are copied into the engine only while it is disabled, so the idle clock level cannot change while the engine runs. The four active-low select lines carry either a guarded one-hot pattern or a binary slave number for an external decoder. They are driven either continuously (manual select) or only while a word is in flight (automatic select). With manual start, each launch command admits exactly one word.

Top module: `spi_host_engine`

## Requirements
- R1: After reset the configuration word is 0x07C09 (host on, divisor field 1, manual select on, select field all ones), so ss_n is 4'hF, sclk is 0, busy is 0, and tx_ready is 0 while en is low.
- R2: While a word is in flight, sclk toggles every 2^N reference cycles, with N taken from config bits 5:3 and N = 0 treated as 1.
- R3: Eight bits are exchanged MSB first, and sclk idles at the active polarity (config bit 1). With phase 0 (config bit 2 clear), both sides sample on leading edges and change data on trailing edges. With phase 1 they change data on leading edges and sample on trailing edges. Each word produces exactly 16 sclk edges.
- R4: In the cycle of the 16th edge, rx_valid pulses for one cycle with the received word on rx_data, and busy is low in the following cycle.
- R5: Writes to the polarity or phase bits while en is high do not change sclk or the shift timing. The written values take effect once en has been low for a clock edge.
- R6: With config bit 9 clear, the select field (bits 13:10) drives ss_n unchanged when it has at most one zero bit. When it has more than one zero bit, ss_n is 4'hF.
- R7: With config bit 9 set, the select field drives ss_n verbatim as a binary code, and 4'hF means no slave.
- R8: With config bit 14 set, ss_n shows the select pattern at all times. With it clear, ss_n shows the pattern only while busy and is 4'hF otherwise.
- R9: With config bit 15 clear, tx_ready is high whenever the engine is enabled and idle, and a word starts when tx_valid and tx_ready are both high.
- R10: With config bit 15 set, tx_ready stays low until a configuration write with bit 16 set. Each such write admits exactly one word, and bit 16 is not stored.
- R11: When en is low or config bit 0 is clear, tx_ready is low. Dropping en while a word is in flight ends it: busy goes low in the next cycle and no rx_valid pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable; polarity and phase load while low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 17 | Configuration word; bit 16 is the launch command |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 8 | Transmit word |
| tx_ready | output | 1 | Engine accepts a word this cycle |
| rx_valid | output | 1 | One-cycle pulse: received word valid |
| rx_data | output | 8 | Received word |
| busy | output | 1 | Word in flight |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low slave-select lines |

## Verification
The hardest condition to reach is a polarity or phase write that arrives while the engine is enabled. From the ports it only shows up as the absence of a change. The stimulus writes inverted polarity and phase while en is high and confirms that the idle sclk level stays put. It then drops en for one edge, sees the level flip, and runs a word whose edge pattern must follow the new phase. A mid-word abort is reached by dropping en a few edges into a slow transfer and then watching for a stray rx_valid pulse.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int CFG_W   = 17;
  localparam int SEL_W   = 4;
  localparam int DIV_W   = 3;
  localparam int POS_GO  = 16;
  localparam logic [CFG_W-1:0] CFG_RESET = 17'h07C09;

  typedef struct packed {
    logic             man_start;
    logic             man_sel;
    logic [SEL_W-1:0] sel_field;
    logic             decoded;
    logic [DIV_W-1:0] div;
    logic             cpha;
    logic             cpol;
    logic             host_on;
  } host_cfg_t;

  function automatic host_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    host_cfg_t c;
    c.host_on   = w[0];
    c.cpol      = w[1];
    c.cpha      = w[2];
    c.div       = w[5:3];
    c.decoded   = w[9];
    c.sel_field = w[13:10];
    c.man_sel   = w[14];
    c.man_start = w[15];
    return c;
  endfunction

  // effective divisor exponent: zero is promoted to one
  function automatic logic [DIV_W-1:0] div_eff(input logic [DIV_W-1:0] n);
    return (n == '0) ? DIV_W'(1) : n;
  endfunction

  // one-hot mode refuses patterns that would select two slaves at once
  function automatic logic [SEL_W-1:0] sel_map(input logic [SEL_W-1:0] f,
                                               input logic dec);
    if (dec) return f;
    return ($countones(~f) <= 1) ? f : '1;
  endfunction
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] n,
  output logic             tick
);
  localparam int CNT_W = 1 << DIV_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  assign half_m1 = (CNT_W'(1) << n) - CNT_W'(1);
  assign tick    = run && (cnt == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= half_m1);
  a_r2_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              cpha,
  input  logic              tick,
  input  logic              miso,
  output logic              active,
  output logic              lvl,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int EDGES = 2 * WORD_W;
  localparam int EW    = $clog2(EDGES);

  logic [EW-1:0]     k;
  logic [WORD_W-1:0] tsh, rsh, rx_nx;
  logic              leading, sample_now, launch_now, last_edge;

  assign leading    = ~k[0];
  assign sample_now = tick && (leading ^ cpha);
  assign launch_now = tick && !(leading ^ cpha) && !(cpha && k == '0);
  assign last_edge  = tick && (k == EW'(EDGES - 1));
  assign rx_nx      = sample_now ? {rsh[WORD_W-2:0], miso} : rsh;
  assign mosi       = tsh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; lvl <= 1'b0; k <= '0;
      tsh <= '0; rsh <= '0; done <= 1'b0; rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0; lvl <= 1'b0; k <= '0;
      end else if (start && !active) begin
        active <= 1'b1; lvl <= 1'b0; k <= '0; tsh <= tx_word;
      end else if (active && tick) begin
        lvl <= ~lvl;
        k   <= k + EW'(1);
        rsh <= rx_nx;
        if (launch_now) tsh <= tsh << 1;
        if (last_edge) begin
          active  <= 1'b0;
          done    <= 1'b1;
          rx_word <= rx_nx;
          k       <= '0;
        end
      end
    end
  end

  a_r4_done_closes_word: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active && !lvl);
  a_r3_mosi_steady_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sample_now && !abort) |=> $stable(mosi));
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SEL_W-1:0]  ss_n
);
  host_cfg_t        c;
  logic             mode_cpol, mode_cpha, pend;
  logic [DIV_W-1:0] div_run;
  logic             engine_on, permit, start_evt, tick, lvl;

  assign engine_on = en && c.host_on;
  assign permit    = !c.man_start || pend;
  assign tx_ready  = engine_on && !busy && permit;
  assign start_evt = tx_valid && tx_ready;
  assign sclk      = mode_cpol ^ lvl;
  assign ss_n      = (c.man_sel || busy) ? sel_map(c.sel_field, c.decoded) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c         <= cfg_unpack(CFG_RESET);
      mode_cpol <= 1'b0;
      mode_cpha <= 1'b0;
      pend      <= 1'b0;
      div_run   <= DIV_W'(1);
    end else begin
      if (cfg_wr) c <= cfg_unpack(cfg_wdata);
      if (!en) begin
        mode_cpol <= c.cpol;
        mode_cpha <= c.cpha;
      end
      if (cfg_wr && cfg_wdata[POS_GO]) pend <= 1'b1;
      else if (start_evt)              pend <= 1'b0;
      if (start_evt) div_run <= div_eff(c.div);
    end
  end

  spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .n(div_run), .tick(tick)
  );

  spi_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .abort(!engine_on),
    .tx_word(tx_data), .cpha(mode_cpha), .tick(tick), .miso(miso),
    .active(busy), .lvl(lvl), .mosi(mosi), .done(rx_valid), .rx_word(rx_data)
  );

  a_r5_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(mode_cpol) && $stable(mode_cpha)));
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == mode_cpol);
  a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    !c.decoded |-> $countones(~ss_n) <= 1);
  a_r8_auto_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!c.man_sel && !busy) |-> ss_n == '1);
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !engine_on |=> !busy && !rx_valid);
  a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r10_one_word: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && c.man_start && !(cfg_wr && cfg_wdata[POS_GO])) |=> !pend);
endmodule

// File: tb/spi_host_engine_test.sv
`timescale 1ns/1ps
module spi_host_engine_test;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, cfg_wr = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic        tx_valid = 1'b0, miso = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready, rx_valid, busy, sclk, mosi;
  logic [7:0]  rx_data;
  logic [3:0]  ss_n;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  spi_host_engine uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  function automatic logic [16:0] mk(bit host, bit pol, bit pha, bit [2:0] n,
      bit dec, bit [3:0] fld, bit msel, bit mst, bit go);
    return {go, mst, msel, fld, dec, 3'b000, n, pha, pol, host};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [16:0] w);
    @(negedge clk); cfg_wdata = w; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic set_mode(input logic [16:0] w);
    en = 1'b0;
    write_cfg(w);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_word(input logic [7:0] tb, input logic [7:0] sb,
      input bit pol, input bit pha, input int half, input logic [3:0] ss_exp);
    int edges = 0, last_t = 0, t = 0, si = 7, guard = 0;
    bit prev, lead, half_ok = 1, got = 0, ss_ok = 1;
    logic [7:0] cap = '0, rxg = '0;
    miso = sb[7];
    @(negedge clk); tx_valid = 1'b1; tx_data = tb;
    while (!tx_ready && guard < 200) begin @(negedge clk); guard++; end
    @(negedge clk); tx_valid = 1'b0;
    prev = pol;
    for (int i = 0; i < 5000; i++) begin
      t++;
      if (sclk !== prev) begin
        edges++;
        lead = (sclk != pol);
        if (edges > 1 && (t - last_t) != half) half_ok = 0;
        last_t = t;
        if (lead ^ pha) cap = {cap[6:0], mosi};
        if (!pha && !lead) begin si--; if (si >= 0) miso = sb[si]; end
        if (pha && lead) begin if (si >= 0) miso = sb[si]; si--; end
        prev = sclk;
      end
      if (busy && ss_n !== ss_exp) ss_ok = 0;
      if (rx_valid) begin rxg = rx_data; got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R4 rx_valid pulse", got, 1);
    chk(edges == 16, "R3 edge count", edges, 16);
    chk(cap == tb, "R3 mosi word MSB first", cap, tb);
    chk(rxg == sb, "R3 R4 received word", rxg, sb);
    chk(half_ok, "R2 half period", half_ok, 1);
    chk(ss_ok, "R8 select during word", ss_ok, 1);
    @(negedge clk);
    chk(!busy && !rx_valid, "R4 busy low after word", {busy, rx_valid}, 0);
    chk(sclk == pol, "R3 idle level", sclk, pol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int idx = 0;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ss_n == 4'hF, "R1 ss_n", ss_n, 4'hF);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(!busy && !tx_ready, "R1 busy/ready", {busy, tx_ready}, 0);
    en = 1'b1; @(negedge clk);
    chk(tx_ready, "R1 R9 default host ready", tx_ready, 1);

    // R2 R3 R9: sweep modes and divisors, automatic select one-hot slave 0
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int n = 0; n < 4; n++) begin
          logic [7:0] tb, sb;
          tb = 8'h3C ^ 8'(idx * 89);
          sb = ~tb ^ 8'(idx * 7);
          set_mode(mk(1, pol[0], pha[0], 3'(n), 0, 4'b1110, 0, 0, 0));
          chk(ss_n == 4'hF, "R8 auto select idle", ss_n, 4'hF);
          run_word(tb, sb, pol[0], pha[0], 1 << (n == 0 ? 1 : n), 4'b1110);
          chk(ss_n == 4'hF, "R8 auto release after word", ss_n, 4'hF);
          idx++;
        end
    // R2 slowest divisor
    set_mode(mk(1, 0, 1, 3'd7, 0, 4'b1101, 0, 0, 0));
    run_word(8'hA7, 8'h5E, 0, 1, 128, 4'b1101);

    // R6 R7 select encodings with manual select
    set_mode(mk(1, 0, 0, 3'd1, 0, 4'b1011, 1, 0, 0));
    chk(ss_n == 4'b1011, "R6 one-hot pattern", ss_n, 4'b1011);
    write_cfg(mk(1, 0, 0, 3'd1, 0, 4'b0011, 1, 0, 0));
    chk(ss_n == 4'hF, "R6 two-low pattern rejected", ss_n, 4'hF);
    write_cfg(mk(1, 0, 0, 3'd1, 1, 4'b0011, 1, 0, 0));
    chk(ss_n == 4'b0011, "R7 decoded code", ss_n, 4'b0011);
    write_cfg(mk(1, 0, 0, 3'd1, 1, 4'hF, 1, 0, 0));
    chk(ss_n == 4'hF, "R7 no-slave code", ss_n, 4'hF);
    write_cfg(mk(1, 0, 0, 3'd1, 1, 4'h5, 1, 0, 0));
    run_word(8'h81, 8'h18, 0, 0, 2, 4'h5);
    chk(ss_n == 4'h5, "R8 manual select held", ss_n, 4'h5);

    // R5 mode change deferred until disable
    set_mode(mk(1, 0, 0, 3'd1, 0, 4'b1110, 0, 0, 0));
    write_cfg(mk(1, 1, 1, 3'd1, 0, 4'b1110, 0, 0, 0));
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R5 polarity held while enabled", sclk, 0);
    en = 1'b0; @(negedge clk);
    chk(sclk == 1'b1, "R5 polarity applied after disable", sclk, 1);
    en = 1'b1; @(negedge clk);
    run_word(8'hC3, 8'h96, 1, 1, 2, 4'b1110);

    // R10 manual start
    set_mode(mk(1, 0, 0, 3'd1, 0, 4'b0111, 1, 1, 0));
    tx_valid = 1'b1; tx_data = 8'h55;
    repeat (20) @(negedge clk);
    chk(!busy && !tx_ready, "R10 held without launch", {busy, tx_ready}, 0);
    tx_valid = 1'b0;
    write_cfg(mk(1, 0, 0, 3'd1, 0, 4'b0111, 1, 1, 1));
    run_word(8'h6B, 8'hD2, 0, 0, 2, 4'b0111);
    chk(!tx_ready, "R10 one word per launch", tx_ready, 0);

    // R11 host bit off
    set_mode(mk(0, 0, 0, 3'd1, 0, 4'b1110, 0, 0, 0));
    tx_valid = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && !tx_ready, "R11 host off", {busy, tx_ready}, 0);
    tx_valid = 1'b0;
    en = 1'b0; @(negedge clk);
    chk(!tx_ready, "R11 en low not ready", tx_ready, 0);

    // R11 abort mid-word
    set_mode(mk(1, 0, 0, 3'd3, 0, 4'b1110, 0, 0, 0));
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'hF0;
    @(negedge clk); tx_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(busy, "R11 word in flight", busy, 1);
    en = 1'b0; @(negedge clk);
    chk(!busy && sclk == 1'b0, "R11 abort ends word", {busy, sclk}, 0);
    seen = 0;
    repeat (40) begin @(negedge clk); if (rx_valid) seen = 1; end
    chk(!seen, "R11 no rx after abort", seen, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule